// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block turns one register request into the full series of primitive commands a byte-level I2C master understands: start, repeated start, byte write, byte read and stop. A request carries a 7-bit device address, a register index, a direction flag and one data byte for writes. The sequencer issues one command at a time and waits for the byte engine to complete it. After every byte written it looks at the slave's acknowledge.

A write goes out as start, address with the direction bit cleared, register index, data, then stop. A read sends the address and the register index in the same way. It then issues a repeated start, so the bus stays held, and sends the address with the direction bit set. It fetches one byte and answers it with a not-acknowledge, so the slave lets go of the data line before the stop. A missing acknowledge cuts the transaction short: the next command is stop, and the result is a failure.

A timeout or stuck-bus report from the byte engine ends the transaction at once, with no stop command. Completion is a single-cycle pulse that carries the status and, for a good read, the received byte.

Top module: `i2c_reg_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high. `req_ready` is high only when the block is idle. A `req_valid` raised while a transaction runs has no effect on the commands issued or on the result.
- R2: The address byte is the 7-bit device address in bits 7:1, with a direction bit in bit 0. The direction bit is 0 for the write-direction address and 1 for the read-direction address.
- R3: Command codes on `eng_cmd` are start=0, repeated start=1, write byte=2, read byte=3, stop=4. A register write issues, in order: start; write address (bit 0 = 0); write register index; write data; stop. The first command appears in the cycle after acceptance.
- R4: A register read issues, in order: start; write address (bit 0 = 0); write register index; repeated start; write address (bit 0 = 1); read byte with `eng_rx_nack` = 1; stop.
- R5: Each command is presented by a single-cycle `eng_cmd_valid` pulse. The next command is issued only after `eng_done` for the previous one.
- R6: If a write-byte command completes with `eng_ack` = 0, no further byte or start command is issued. The next command is stop, and the transaction reports failure.
- R7: The value of `eng_ack` is ignored on completion of any command other than write byte.
- R8: `eng_fault` together with `eng_done` ends the transaction immediately with failure, and no stop is issued.
- R9: `done` is high for exactly one cycle per accepted request. In that cycle `ok` gives success. `rd_data` holds the received byte after a successful read and is 0 after a write or after any failed transaction.
- R10: After reset, `req_ready` = 1, `done` = 0 and `eng_cmd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, request may be taken |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | DEV_ADDR_W | 7-bit device address |
| req_reg | input | DATA_W | Register index |
| req_wdata | input | DATA_W | Data byte for a write |
| eng_cmd_valid | output | 1 | Command strobe to the byte engine |
| eng_cmd | output | 3 | Command code |
| eng_tx_byte | output | DATA_W | Byte to send for write-byte commands |
| eng_rx_nack | output | 1 | Answer a received byte with not-acknowledge |
| eng_done | input | 1 | Byte engine finished the current command |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_fault | input | 1 | Timeout or stuck bus on the current command |
| eng_rx_byte | input | DATA_W | Byte received by a read-byte command |
| done | output | 1 | Transaction finished, one cycle |
| ok | output | 1 | Success status, valid with done |
| rd_data | output | DATA_W | Read result, valid with done |

## Verification
Reads and writes that succeed check the two command orderings and the address direction bit against a bench model. The bench then places a not-acknowledge on each write position: the device address, the register index, the data byte and the read-direction address. This separates an early jump to stop from a sequence that runs on. A low acknowledge on start, repeated start and read completions must change nothing. Faults are injected on the first command, the read and the stop, which shows that the stop is skipped only in the fault case. Random requests with random engine latency, acknowledge and fault positions, along with a competing request while busy, cover the rest.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
   typedef enum logic [2:0] {
      CMD_START   = 3'd0,
      CMD_RESTART = 3'd1,
      CMD_WRITE   = 3'd2,
      CMD_READ    = 3'd3,
      CMD_STOP    = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_FIN
   } seq_state_e;

   localparam int unsigned STEP_W = 3;
endpackage

// File: rtl/i2c_seq_step.sv
`timescale 1ns/1ps
module i2c_seq_step
   import i2c_seq_pkg::*;
#(
   parameter int unsigned DEV_ADDR_W = 7,
   parameter int unsigned DATA_W     = 8
) (
   input  logic [STEP_W-1:0]     step,
   input  logic                  is_read,
   input  logic [DEV_ADDR_W-1:0] dev,
   input  logic [DATA_W-1:0]     reg_idx,
   input  logic [DATA_W-1:0]     wdata,
   output cmd_e                  cmd,
   output logic [DATA_W-1:0]     tx,
   output logic [STEP_W-1:0]     stop_step
);
   localparam logic [STEP_W-1:0] WR_STOP = STEP_W'(4);
   localparam logic [STEP_W-1:0] RD_STOP = STEP_W'(6);

   assign stop_step = is_read ? RD_STOP : WR_STOP;

   always_comb begin
      cmd = CMD_STOP;
      tx  = '0;
      case (step)
         STEP_W'(0): cmd = CMD_START;
         STEP_W'(1): begin
            cmd = CMD_WRITE;
            tx  = {dev, 1'b0};
         end
         STEP_W'(2): begin
            cmd = CMD_WRITE;
            tx  = reg_idx;
         end
         STEP_W'(3): begin
            if (is_read) begin
               cmd = CMD_RESTART;
            end else begin
               cmd = CMD_WRITE;
               tx  = wdata;
            end
         end
         STEP_W'(4): begin
            if (is_read) begin
               cmd = CMD_WRITE;
               tx  = {dev, 1'b1};
            end
         end
         STEP_W'(5): cmd = is_read ? CMD_READ : CMD_STOP;
         default:    cmd = CMD_STOP;
      endcase
   end
endmodule

// File: rtl/i2c_seq_result.sv
`timescale 1ns/1ps
module i2c_seq_result #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          CLEAR_ON_FAIL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_byte,
   input  logic              fail_set,
   output logic [DATA_W-1:0] rd_data,
   output logic              fail
);
   logic [DATA_W-1:0] rd_q;
   logic              fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         fail_q <= 1'b0;
      end else if (clear) begin
         rd_q   <= '0;
         fail_q <= 1'b0;
      end else begin
         if (cap_en)   rd_q   <= cap_byte;
         if (fail_set) fail_q <= 1'b1;
      end
   end

   assign fail = fail_q;

   generate
      if (CLEAR_ON_FAIL) begin : g_mask
         assign rd_data = fail_q ? '0 : rd_q;
      end else begin : g_raw
         assign rd_data = rd_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_reg_seq.sv
`timescale 1ns/1ps
module i2c_reg_seq
   import i2c_seq_pkg::*;
#(
   parameter int unsigned DEV_ADDR_W    = 7,
   parameter int unsigned DATA_W        = 8,
   parameter bit          CLEAR_ON_FAIL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_read,
   input  logic [DEV_ADDR_W-1:0] req_dev,
   input  logic [DATA_W-1:0]     req_reg,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  eng_cmd_valid,
   output logic [2:0]            eng_cmd,
   output logic [DATA_W-1:0]     eng_tx_byte,
   output logic                  eng_rx_nack,
   input  logic                  eng_done,
   input  logic                  eng_ack,
   input  logic                  eng_fault,
   input  logic [DATA_W-1:0]     eng_rx_byte,
   output logic                  done,
   output logic                  ok,
   output logic [DATA_W-1:0]     rd_data
);
   generate
      if (DEV_ADDR_W + 1 != DATA_W) begin : g_width_bad
         $error("address plus direction bit must fill one data byte");
      end
   endgenerate

   seq_state_e              state;
   logic [STEP_W-1:0]       step;
   logic                    lat_read;
   logic [DEV_ADDR_W-1:0]   lat_dev;
   logic [DATA_W-1:0]       lat_reg;
   logic [DATA_W-1:0]       lat_wdata;
   cmd_e                    cur_cmd;
   logic [STEP_W-1:0]       stop_step;
   logic                    accept, waiting, fin_evt, nak_evt, fail_set, cap_en, fail;

   i2c_seq_step #(.DEV_ADDR_W(DEV_ADDR_W), .DATA_W(DATA_W)) u_step (
      .step      (step),
      .is_read   (lat_read),
      .dev       (lat_dev),
      .reg_idx   (lat_reg),
      .wdata     (lat_wdata),
      .cmd       (cur_cmd),
      .tx        (eng_tx_byte),
      .stop_step (stop_step)
   );

   assign accept   = (state == ST_IDLE) && req_valid;
   assign waiting  = (state == ST_WAIT) && eng_done;
   assign fin_evt  = waiting && (eng_fault || cur_cmd == CMD_STOP);
   assign nak_evt  = waiting && !eng_fault && (cur_cmd == CMD_WRITE) && !eng_ack;
   assign fail_set = (waiting && eng_fault) || nak_evt;
   assign cap_en   = waiting && !eng_fault && (cur_cmd == CMD_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         step      <= '0;
         lat_read  <= 1'b0;
         lat_dev   <= '0;
         lat_reg   <= '0;
         lat_wdata <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               lat_read  <= req_read;
               lat_dev   <= req_dev;
               lat_reg   <= req_reg;
               lat_wdata <= req_wdata;
               step      <= '0;
               state     <= ST_ISSUE;
            end
            ST_ISSUE: state <= ST_WAIT;
            ST_WAIT: if (eng_done) begin
               if (fin_evt) begin
                  state <= ST_FIN;
               end else if (nak_evt) begin
                  step  <= stop_step;
                  state <= ST_ISSUE;
               end else begin
                  step  <= step + 1'b1;
                  state <= ST_ISSUE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   i2c_seq_result #(.DATA_W(DATA_W), .CLEAR_ON_FAIL(CLEAR_ON_FAIL)) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .cap_en   (cap_en),
      .cap_byte (eng_rx_byte),
      .fail_set (fail_set),
      .rd_data  (rd_data),
      .fail     (fail)
   );

   assign req_ready     = (state == ST_IDLE);
   assign eng_cmd_valid = (state == ST_ISSUE);
   assign eng_cmd       = cur_cmd;
   assign eng_rx_nack   = 1'b1;
   assign done          = (state == ST_FIN);
   assign ok            = !fail;

   assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   assert_first_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> (eng_cmd_valid && eng_cmd == 3'd0));
   assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |=> !eng_cmd_valid);
   assert_nak_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && eng_done && !eng_fault && eng_cmd == 3'd2 && !eng_ack)
      |=> (eng_cmd_valid && eng_cmd == 3'd4));
   assert_fault_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && eng_done && eng_fault) |=> (done && !ok && !eng_cmd_valid));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/i2c_reg_seq_test.sv
`timescale 1ns/1ps
module i2c_reg_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_read = 1'b0;
   logic [6:0] req_dev = '0;
   logic [7:0] req_reg = '0;
   logic [7:0] req_wdata = '0;
   logic       eng_cmd_valid;
   logic [2:0] eng_cmd;
   logic [7:0] eng_tx_byte;
   logic       eng_rx_nack;
   logic       eng_done = 1'b0;
   logic       eng_ack = 1'b0;
   logic       eng_fault = 1'b0;
   logic [7:0] eng_rx_byte = '0;
   logic       done, ok;
   logic [7:0] rd_data;

   always #2.5 clk = ~clk;

   i2c_reg_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
      .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_tx_byte(eng_tx_byte),
      .eng_rx_nack(eng_rx_nack), .eng_done(eng_done), .eng_ack(eng_ack),
      .eng_fault(eng_fault), .eng_rx_byte(eng_rx_byte), .done(done), .ok(ok),
      .rd_data(rd_data)
   );

   int n_checks = 0;
   int n_errors = 0;

   // engine plan and command log
   int         plan_nak, plan_fault;
   logic [7:0] plan_rx;
   int         log_n;
   logic [2:0] log_cmd  [0:15];
   logic [7:0] log_byte [0:15];
   logic       log_nack [0:15];

   // expected values
   int         exp_n;
   logic [2:0] exp_cmd  [0:15];
   logic [7:0] exp_byte [0:15];
   logic       exp_ok;
   logic [7:0] exp_rd;

   task automatic check(input logic cond, input string req, input int act, input int expv);
      n_checks++;
      if (!cond) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         eng_done  = 1'b0;
         eng_fault = 1'b0;
         if (eng_cmd_valid) begin
            int k;
            k = log_n;
            if (k < 16) begin
               log_cmd[k]  = eng_cmd;
               log_byte[k] = eng_tx_byte;
               log_nack[k] = eng_rx_nack;
            end
            log_n = log_n + 1;
            repeat (1 + ($urandom % 3)) @(negedge clk);
            eng_done    = 1'b1;
            eng_ack     = (k != plan_nak);
            eng_fault   = (k == plan_fault);
            eng_rx_byte = plan_rx;
         end
      end
   end

   function automatic logic [2:0] full_cmd(input int s, input logic rd);
      case (s)
         0: return 3'd0;
         1, 2: return 3'd2;
         3: return rd ? 3'd1 : 3'd2;
         4: return rd ? 3'd2 : 3'd4;
         5: return rd ? 3'd3 : 3'd4;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [7:0] full_byte(input int s, input logic rd, input logic [6:0] dv,
                                            input logic [7:0] rg, input logic [7:0] wd);
      case (s)
         1: return {dv, 1'b0};
         2: return rg;
         3: return rd ? 8'h00 : wd;
         4: return rd ? {dv, 1'b1} : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   task automatic build_expect(input logic rd, input logic [6:0] dv, input logic [7:0] rg,
                               input logic [7:0] wd, input int nak, input int flt,
                               input logic [7:0] rx);
      int s = 0;
      int k = 0;
      logic fin = 1'b0;
      exp_ok = 1'b1;
      exp_rd = 8'h00;
      while (!fin) begin
         exp_cmd[k]  = full_cmd(s, rd);
         exp_byte[k] = full_byte(s, rd, dv, rg, wd);
         if (k == flt) begin
            exp_ok = 1'b0;
            fin = 1'b1;
         end else if (exp_cmd[k] == 3'd2 && k == nak) begin
            exp_ok = 1'b0;
            s = rd ? 6 : 4;
         end else if (exp_cmd[k] == 3'd4) begin
            fin = 1'b1;
         end else begin
            if (exp_cmd[k] == 3'd3) exp_rd = rx;
            s++;
         end
         k++;
      end
      exp_n = k;
      if (!exp_ok) exp_rd = 8'h00;
   endtask

   task automatic run_txn(input logic rd, input logic [6:0] dv, input logic [7:0] rg,
                          input logic [7:0] wd, input int nak, input int flt,
                          input logic [7:0] rx, input string tag);
      int guard = 0;
      build_expect(rd, dv, rg, wd, nak, flt, rx);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      plan_nak   = nak;
      plan_fault = flt;
      plan_rx    = rx;
      log_n      = 0;
      req_read = rd; req_dev = dv; req_reg = rg; req_wdata = wd;
      req_valid = 1'b1;
      @(negedge clk);
      // R1: competing request while busy must be ignored
      check(req_ready == 1'b0, {tag, " R1 ready while busy"}, req_ready, 0);
      req_read = ~rd; req_dev = ~dv; req_reg = ~rg; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      check(done == 1'b1, {tag, " R9 done seen"}, done, 1);
      check(ok == exp_ok, {tag, " R6 R7 R8 status"}, ok, exp_ok);
      check(rd_data == exp_rd, {tag, " R9 read data"}, rd_data, exp_rd);
      check(log_n == exp_n, {tag, " R3 R4 R5 R6 R8 command count"}, log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n && i < 16; i++) begin
         check(log_cmd[i] == exp_cmd[i], {tag, " R1 R3 R4 command code"}, log_cmd[i], exp_cmd[i]);
         if (exp_cmd[i] == 3'd2)
            check(log_byte[i] == exp_byte[i], {tag, " R2 written byte"}, log_byte[i], exp_byte[i]);
         if (exp_cmd[i] == 3'd3)
            check(log_nack[i] == 1'b1, {tag, " R4 read nack"}, log_nack[i], 1);
      end
      @(negedge clk);
      check(done == 1'b0, {tag, " R9 single-cycle done"}, done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      plan_nak = -1; plan_fault = -1; plan_rx = 8'h00; log_n = 0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(req_ready == 1'b1, "R10 ready", req_ready, 1);
      check(done == 1'b0, "R10 done", done, 0);
      check(eng_cmd_valid == 1'b0, "R10 cmd valid", eng_cmd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R10 ready after release", req_ready, 1);

      run_txn(1'b0, 7'h5D, 8'h20, 8'hBA, -1, -1, 8'h00, "R3 write ok");
      run_txn(1'b1, 7'h5D, 8'h0F, 8'h00, -1, -1, 8'hBD, "R4 read ok");
      run_txn(1'b0, 7'h50, 8'h10, 8'h33, 1, -1, 8'h00, "R6 write nak addr");
      run_txn(1'b0, 7'h50, 8'h10, 8'h33, 3, -1, 8'h00, "R6 write nak data");
      run_txn(1'b1, 7'h50, 8'h11, 8'h00, 2, -1, 8'h77, "R6 read nak reg");
      run_txn(1'b1, 7'h50, 8'h12, 8'h00, 4, -1, 8'h77, "R6 read nak addr R");
      run_txn(1'b1, 7'h21, 8'h01, 8'h00, 0, -1, 8'hC3, "R7 ack low on start");
      run_txn(1'b1, 7'h21, 8'h02, 8'h00, 3, -1, 8'h3C, "R7 ack low on restart");
      run_txn(1'b1, 7'h21, 8'h03, 8'h00, 5, -1, 8'h5A, "R7 ack low on read");
      run_txn(1'b0, 7'h7F, 8'hFF, 8'hFF, -1, 0, 8'h00, "R8 fault on start");
      run_txn(1'b1, 7'h00, 8'h00, 8'h00, -1, 5, 8'hEE, "R8 fault on read");
      run_txn(1'b0, 7'h12, 8'h34, 8'h56, -1, 4, 8'h00, "R8 fault on stop");

      for (int t = 0; t < 200; t++) begin
         logic rd;
         int nak, flt;
         rd  = 1'($urandom % 2);
         nak = ($urandom % 2) ? -1 : int'($urandom % 7);
         flt = ($urandom % 4) != 0 ? -1 : int'($urandom % 7);
         run_txn(rd, 7'($urandom), 8'($urandom), 8'($urandom), nak, flt, 8'($urandom),
                 "R3 R4 R6 R8 random");
      end

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule